// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the strobe timing and the port multiplexing that an 8-bit microcontroller core needs to reach external code and data memory over a shared address/data bus. The oscillator clock drives it directly. One machine cycle lasts twelve clocks, split into six states of two clocks each. At the start of every machine cycle the core presents one access kind, an address, write data, the current value of its high-port register and an address-latch-disable control bit. During that cycle the sequencer drives the address-latch strobe, the program-store strobe, the read and write strobes, the low port and the high port. It hands the byte it captured from the low port back to the core together with a one-clock valid pulse.

Each machine cycle has two access slots. A code cycle fetches one byte in each slot. The second slot takes its address from the address input one clock before mid-cycle. A data cycle uses only the first slot's address phase and then gives the rest of the cycle to a single read or write. Its second latch pulse and both program-store pulses are left out. The reset input is filtered and takes effect only after it has been held high for two full machine cycles.

Top module: `xbus_seq`

## Requirements
- R1: The internal reset engages only after `rst_in` has been high on 24 consecutive rising edges. A shorter high pulse changes nothing. From the cycle after it engages, and for as long as it is held, the outputs sit at idle: `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `lo_oe`=0, `lo_out`=0, `hi_out`=FF, `rvalid`=0. The first cycle after release is phase 0 with no access latched.
- R2: Clock phases are numbered 0 to 11 within a machine cycle. `ale` is high for exactly one clock at phase 0 and at phase 6, so it pulses every sixth clock.
- R3: In a data cycle (`req_op` 3 = 8-bit-address data, 4 = 16-bit-address data), `ale` pulses at phase 0 only. The phase-6 pulse is omitted.
- R4: In a code cycle (`req_op` 1 = instruction fetch, 2 = code-table read), `psen_n` is low at phases 2 to 4 and 8 to 10, which gives two pulses. It stays high in every other cycle kind.
- R5: In an idle cycle (`req_op` 0, and codes 5 to 7 are treated as 0), `ale` pulses as in R2 when `ale_off`=0 and stays low for the whole cycle when `ale_off`=1.
- R6: `ale_off` has no effect in code cycles or data cycles. `ale` still pulses as in R2 or R3.
- R7: `hi_out` shows the following. In a code cycle it shows the high address byte of the current slot's address. In a 16-bit data cycle it shows the high byte of the latched address. In 8-bit data cycles and idle cycles it shows the latched `p2_reg` value.
- R8: `lo_oe` is high, with `lo_out` carrying the slot's low address byte, at phases 0 to 1 of code and data cycles and at phases 6 to 7 of code cycles. In write cycles `lo_oe` is high with `lo_out` = write data at phases 2 to 10. At all other times `lo_oe`=0 and `lo_out`=0.
- R9: In a data cycle with `req_wr`=0, `rd_n` is low at phases 2 to 9. With `req_wr`=1, `wr_n` is low over the same phases. The two are never low together, and neither is low in other cycles.
- R10: `lo_in` is sampled at phases 4 and 10 of code cycles and at phase 9 of read cycles. The byte appears on `rdata` with `rvalid`=1 for the one following clock. `rdata` holds its value until the next capture.
- R11: `req_op`, `req_wr`, `req_addr`, `req_wdata`, `p2_reg` and `ale_off` are sampled on the edge that ends phase 11. `req_addr` is sampled again on the edge that ends phase 5, for the second slot. Changes at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Raw reset request, active high, filtered |
| req_op | input | 3 | Access kind for the next machine cycle |
| req_wr | input | 1 | Data access is a write |
| req_addr | input | 16 | Access address (slot 0 at cycle start, slot 1 at mid-cycle) |
| req_wdata | input | 8 | Byte to write in a data write cycle |
| p2_reg | input | 8 | High-port register value for 8-bit-address and idle cycles |
| ale_off | input | 1 | Suppress address-latch pulses in idle cycles |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low port drive value (address low byte or write data) |
| lo_oe | output | 1 | Low port drive enable |
| lo_in | input | 8 | Low port input value (code or read data) |
| hi_out | output | 8 | High port value (address high byte or register contents) |
| rdata | output | 8 | Last captured byte |
| rvalid | output | 1 | One-clock pulse marking a new `rdata` |

## Verification
Stimulus runs back-to-back machine cycles of every access kind: idle with the latch-disable bit clear and set, fetch and table read with it set, 8-bit and 16-bit data reads and writes, an out-of-range kind code, and then a long random mix. Each cycle uses fresh addresses in both slots. The idle-versus-fetch pair shows whether the disable bit is gated by access kind. The 8-bit versus 16-bit pair shows where the high port takes its value. Read versus write shows which strobe fires and whether the low port drives data or floats. A short reset pulse and a long reset pulse, both given mid-traffic, show that the two-machine-cycle filter works. Per-cycle counts of latch pulses, program-store clocks and capture pulses confirm the cadence of each kind independently of the per-clock comparison.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_FETCH  = 3'd1,
        OP_TABLE  = 3'd2,
        OP_DATA8  = 3'd3,
        OP_DATA16 = 3'd4
    } xop_e;

    // unknown codes fall back to an idle cycle
    function automatic xop_e to_op(input logic [2:0] code);
        case (code)
            3'd1:    return OP_FETCH;
            3'd2:    return OP_TABLE;
            3'd3:    return OP_DATA8;
            3'd4:    return OP_DATA16;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic logic is_code(input xop_e op);
        return (op == OP_FETCH) || (op == OP_TABLE);
    endfunction

    function automatic logic is_data(input xop_e op);
        return (op == OP_DATA8) || (op == OP_DATA16);
    endfunction

endpackage

// File: rtl/xbus_rst_filter.sv
module xbus_rst_filter #(
    parameter int LIMIT = 24
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_q
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM  = CW'(LIMIT);
    localparam logic [CW-1:0] LIM1 = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rst;
    } flt_t;

    flt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (!rst_in) begin
            f_d.cnt = '0;
        end else if (f_q.cnt != LIM) begin
            f_d.cnt = f_q.cnt + 1'b1;
        end
        f_d.rst = rst_in && (f_q.cnt >= LIM1);
    end

    always_ff @(posedge clk) begin
        f_q <= f_d;
    end

    assign rst_q = f_q.rst;

endmodule

// File: rtl/xbus_timebase.sv
module xbus_timebase #(
    parameter int MC = 12,
    parameter int PW = $clog2(MC)
) (
    input  logic          clk,
    input  logic          clr,
    output logic [PW-1:0] phase,
    output logic          at_end,
    output logic          at_mid
);
    localparam logic [PW-1:0] LAST = PW'(MC - 1);
    localparam logic [PW-1:0] MIDM = PW'(MC / 2 - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q + 1'b1;
        if (clr || phase_q == LAST) begin
            phase_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        phase_q <= phase_d;
    end

    assign phase  = phase_q;
    assign at_end = (phase_q == LAST);
    assign at_mid = (phase_q == MIDM);

    // R2: the machine cycle wraps to phase 0 after its last clock
    a_r2_phase_wrap: assert property (@(posedge clk) disable iff (clr)
        (phase_q == LAST) |=> (phase_q == '0));

endmodule

// File: rtl/xbus_decode.sv
module xbus_decode import xbus_pkg::*; #(
    parameter int DW         = 8,
    parameter int STATE_CLKS = 2,
    parameter int STATES     = 6,
    parameter int PW         = $clog2(STATE_CLKS * STATES)
) (
    input  logic            idle,
    input  logic [PW-1:0]   phase,
    input  xop_e            op,
    input  logic            wr,
    input  logic [2*DW-1:0] a0,
    input  logic [2*DW-1:0] a1,
    input  logic [DW-1:0]   wd,
    input  logic [DW-1:0]   p2,
    input  logic            aoff,
    output logic            ale,
    output logic            psen_n,
    output logic            rd_n,
    output logic            wr_n,
    output logic [DW-1:0]   lo_out,
    output logic            lo_oe,
    output logic [DW-1:0]   hi_out,
    output logic            cap
);
    localparam int MC = STATE_CLKS * STATES;
    localparam int HALF = MC / 2;
    localparam logic [PW-1:0] P_HALF  = PW'(HALF);
    localparam logic [PW-1:0] P_SC    = PW'(STATE_CLKS);
    localparam logic [PW-1:0] P_PSEND = PW'(HALF - STATE_CLKS);
    localparam logic [PW-1:0] P_RWEND = PW'(MC - 1 - STATE_CLKS);
    localparam logic [PW-1:0] P_WDEND = PW'(MC - STATE_CLKS);

    typedef struct packed {
        logic          ale;
        logic          psen_n;
        logic          rd_n;
        logic          wr_n;
        logic          oe;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic          cap;
    } pins_t;

    pins_t pins_d;
    logic          second, code, data, adr_ph, psen_w, rw_w, wd_w;
    logic [PW-1:0] q;
    logic [2*DW-1:0] slot_a;

    always_comb begin
        second = (phase >= P_HALF);
        q      = second ? (phase - P_HALF) : phase;
        code   = is_code(op);
        data   = is_data(op);
        slot_a = second ? a1 : a0;
        psen_w = (q >= P_SC) && (q <= P_PSEND);
        rw_w   = (phase >= P_SC) && (phase <= P_RWEND);
        wd_w   = (phase >= P_SC) && (phase <= P_WDEND);
        adr_ph = (q < P_SC) && (code || (data && !second));

        pins_d        = '0;
        pins_d.psen_n = 1'b1;
        pins_d.rd_n   = 1'b1;
        pins_d.wr_n   = 1'b1;
        pins_d.hi     = '1;
        if (!idle) begin
            pins_d.ale = ((phase == '0) || (phase == P_HALF && !data))
                         && (code || data || !aoff);
            pins_d.psen_n = !(code && psen_w);
            pins_d.rd_n   = !(data && !wr && rw_w);
            pins_d.wr_n   = !(data && wr && rw_w);
            if (adr_ph) begin
                pins_d.oe = 1'b1;
                pins_d.lo = slot_a[DW-1:0];
            end else if (data && wr && wd_w) begin
                pins_d.oe = 1'b1;
                pins_d.lo = wd;
            end
            if (code) begin
                pins_d.hi = slot_a[2*DW-1:DW];
            end else if (op == OP_DATA16) begin
                pins_d.hi = a0[2*DW-1:DW];
            end else begin
                pins_d.hi = p2;
            end
            pins_d.cap = (code && q == P_PSEND) ||
                         (data && !wr && phase == P_RWEND);
        end
    end

    assign ale    = pins_d.ale;
    assign psen_n = pins_d.psen_n;
    assign rd_n   = pins_d.rd_n;
    assign wr_n   = pins_d.wr_n;
    assign lo_out = pins_d.lo;
    assign lo_oe  = pins_d.oe;
    assign hi_out = pins_d.hi;
    assign cap    = pins_d.cap;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq import xbus_pkg::*; #(
    parameter int DW         = 8,
    parameter int STATE_CLKS = 2,
    parameter int STATES     = 6,
    parameter int RST_MCYC   = 2
) (
    input  logic            clk,
    input  logic            rst_in,
    input  logic [2:0]      req_op,
    input  logic            req_wr,
    input  logic [2*DW-1:0] req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW-1:0]   p2_reg,
    input  logic            ale_off,
    output logic            ale,
    output logic            psen_n,
    output logic            rd_n,
    output logic            wr_n,
    output logic [DW-1:0]   lo_out,
    output logic            lo_oe,
    input  logic [DW-1:0]   lo_in,
    output logic [DW-1:0]   hi_out,
    output logic [DW-1:0]   rdata,
    output logic            rvalid
);
    localparam int AW = 2 * DW;
    localparam int MC = STATE_CLKS * STATES;
    localparam int PW = $clog2(MC);

    typedef struct packed {
        xop_e          op;
        logic          wr;
        logic [AW-1:0] a0;
        logic [AW-1:0] a1;
        logic [DW-1:0] wd;
        logic [DW-1:0] p2;
        logic          aoff;
        logic [DW-1:0] rdat;
        logic          rv;
    } st_t;

    localparam st_t ST_RST = '{op: OP_NONE, wr: 1'b0, a0: '0, a1: '0,
                               wd: '0, p2: '1, aoff: 1'b0, rdat: '0, rv: 1'b0};

    logic          rst_q, at_end, at_mid, cap;
    logic [PW-1:0] phase;
    st_t           s_d, s_q;

    xbus_rst_filter #(.LIMIT(RST_MCYC * MC)) u_rst (
        .clk    (clk),
        .rst_in (rst_in),
        .rst_q  (rst_q)
    );

    xbus_timebase #(.MC(MC), .PW(PW)) u_time (
        .clk    (clk),
        .clr    (rst_q),
        .phase  (phase),
        .at_end (at_end),
        .at_mid (at_mid)
    );

    xbus_decode #(.DW(DW), .STATE_CLKS(STATE_CLKS), .STATES(STATES), .PW(PW)) u_dec (
        .idle   (rst_q),
        .phase  (phase),
        .op     (s_q.op),
        .wr     (s_q.wr),
        .a0     (s_q.a0),
        .a1     (s_q.a1),
        .wd     (s_q.wd),
        .p2     (s_q.p2),
        .aoff   (s_q.aoff),
        .ale    (ale),
        .psen_n (psen_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .lo_out (lo_out),
        .lo_oe  (lo_oe),
        .hi_out (hi_out),
        .cap    (cap)
    );

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        if (at_end) begin
            s_d.op   = to_op(req_op);
            s_d.wr   = req_wr;
            s_d.a0   = req_addr;
            s_d.a1   = req_addr;
            s_d.wd   = req_wdata;
            s_d.p2   = p2_reg;
            s_d.aoff = ale_off;
        end
        if (at_mid) begin
            s_d.a1 = req_addr;
        end
        if (cap) begin
            s_d.rdat = lo_in;
            s_d.rv   = 1'b1;
        end
        if (rst_q) begin
            s_d = ST_RST;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign rdata  = s_q.rdat;
    assign rvalid = s_q.rv;

    // R1: while reset is engaged every strobe and port is idle
    a_r1_idle_in_reset: assert property (@(posedge clk) disable iff (!rst_in)
        rst_q |-> (!ale && psen_n && rd_n && wr_n && !lo_oe && !rvalid));

    // R2: an address latch pulse lasts a single clock
    a_r2_ale_one_clk: assert property (@(posedge clk) disable iff (rst_in || rst_q)
        ale |=> !ale);

    // R3: no latch pulse while a data strobe is active
    a_r3_no_ale_in_data: assert property (@(posedge clk) disable iff (rst_in || rst_q)
        (!rd_n || !wr_n) |-> !ale);

    // R4: program-store strobe never overlaps a data strobe
    a_r4_psen_vs_rdwr: assert property (@(posedge clk) disable iff (rst_in || rst_q)
        !psen_n |-> (rd_n && wr_n));

    // R8: low port floats while code bytes are being read
    a_r8_float_on_psen: assert property (@(posedge clk) disable iff (rst_in || rst_q)
        !psen_n |-> !lo_oe);

    // R9: read and write strobes are exclusive
    a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (rst_in || rst_q)
        !(!rd_n && !wr_n));

    // R10: a valid pulse follows a clock with a read strobe low
    a_r10_valid_after_strobe: assert property (@(posedge clk) disable iff (rst_in || rst_q)
        rvalid |-> $past(!psen_n || !rd_n));

endmodule

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_in = 1'b0;
    logic [2:0]  req_op = '0;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  p2_reg = 8'hFF;
    logic        ale_off = 1'b0;
    logic [7:0]  lo_in = 8'h5A;
    logic        ale, psen_n, rd_n, wr_n, lo_oe, rvalid;
    logic [7:0]  lo_out, hi_out, rdata;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_seq dut (
        .clk(clk), .rst_in(rst_in), .req_op(req_op), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .p2_reg(p2_reg),
        .ale_off(ale_off), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in),
        .hi_out(hi_out), .rdata(rdata), .rvalid(rvalid)
    );

    // ---------------- behavioural reference ----------------
    int          m_cnt = 0;
    bit          m_rst = 1'b0;
    bit          m_live = 1'b0;
    int          m_ph = 0;
    int          m_op = 0;
    bit          m_wr = 1'b0, m_aoff = 1'b0, m_rv = 1'b0;
    logic [15:0] m_a0 = '0, m_a1 = '0;
    logic [7:0]  m_wd = '0, m_p2 = 8'hFF, m_rd = '0;

    function automatic int kind(input logic [2:0] c);
        return (c <= 3'd4) ? int'(c) : 0;
    endfunction

    always @(posedge clk) begin
        bit code, data, cap;
        code = (m_op == 1 || m_op == 2);
        data = (m_op == 3 || m_op == 4);
        cap  = !m_rst && ((code && (m_ph == 4 || m_ph == 10)) ||
                          (data && !m_wr && m_ph == 9));
        if (m_rst) begin
            m_ph = 0; m_op = 0; m_wr = 0; m_a0 = '0; m_a1 = '0; m_wd = '0;
            m_p2 = 8'hFF; m_aoff = 0; m_rd = '0; m_rv = 0;
        end else begin
            m_rv = 0;
            if (cap) begin m_rd = lo_in; m_rv = 1; end
            if (m_ph == 11) begin
                m_op = kind(req_op); m_wr = req_wr; m_a0 = req_addr; m_a1 = req_addr;
                m_wd = req_wdata; m_p2 = p2_reg; m_aoff = ale_off; m_ph = 0;
            end else begin
                if (m_ph == 5) m_a1 = req_addr;
                m_ph = m_ph + 1;
            end
        end
        m_cnt = rst_in ? m_cnt + 1 : 0;
        m_rst = rst_in && (m_cnt >= 24);
        if (m_rst) m_live = 1'b1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (phase %0d op %0d)", tag, act, exp, m_ph, m_op);
        end
    endtask

    // per-cycle tallies for directed cadence checks
    int n_ale = 0, n_psen = 0, n_rv = 0;
    bit cyc_full = 1'b0;

    always @(negedge clk) begin
        bit code, data, e_ale, e_psen, e_rd, e_wr, e_oe;
        int q;
        logic [7:0] e_lo, e_hi;
        cyc++;
        if (m_live && !done) begin
            code = (m_op == 1 || m_op == 2);
            data = (m_op == 3 || m_op == 4);
            q = m_ph % 6;
            e_ale  = !m_rst && ((m_ph == 0) || (m_ph == 6 && !data)) && (code || data || !m_aoff);
            e_psen = !(!m_rst && code && q >= 2 && q <= 4);
            e_rd   = !(!m_rst && data && !m_wr && m_ph >= 2 && m_ph <= 9);
            e_wr   = !(!m_rst && data && m_wr && m_ph >= 2 && m_ph <= 9);
            e_oe = 0; e_lo = '0;
            if (!m_rst) begin
                if (m_ph < 2 && (code || data)) begin e_oe = 1; e_lo = m_a0[7:0]; end
                else if (m_ph >= 6 && m_ph < 8 && code) begin e_oe = 1; e_lo = m_a1[7:0]; end
                else if (data && m_wr && m_ph >= 2 && m_ph <= 10) begin e_oe = 1; e_lo = m_wd; end
            end
            if (m_rst) e_hi = 8'hFF;
            else if (code) e_hi = (m_ph < 6) ? m_a0[15:8] : m_a1[15:8];
            else if (m_op == 4) e_hi = m_a0[15:8];
            else e_hi = m_p2;

            check(ale === e_ale, m_rst ? "R1 ale idle" : (data ? "R3 ale" : "R2/R5/R6 ale"), ale, e_ale);
            check(psen_n === e_psen, "R4 psen_n", psen_n, e_psen);
            check(rd_n === e_rd && wr_n === e_wr, "R9 rd_n/wr_n", {rd_n, wr_n}, {e_rd, e_wr});
            check(lo_oe === e_oe && lo_out === e_lo, "R8 low port", {lo_oe, lo_out}, {e_oe, e_lo});
            check(hi_out === e_hi, "R7 high port", hi_out, e_hi);
            check(rvalid === m_rv && rdata === m_rd, "R10 capture", {rvalid, rdata}, {m_rv, m_rd});

            // directed per-machine-cycle cadence (R2, R3, R4, R5, R6, R10)
            if (m_rst) cyc_full = 0;
            else begin
                if (m_ph == 0) begin cyc_full = 1; n_ale = 0; n_psen = 0; n_rv = 0; end
                n_ale  += int'(ale);
                n_psen += int'(!psen_n);
                n_rv   += int'(rvalid);
                if (m_ph == 11 && cyc_full) begin
                    int x_ale, x_psen, x_rv;
                    x_ale  = data ? 1 : ((code || !m_aoff) ? 2 : 0);
                    x_psen = code ? 6 : 0;
                    x_rv   = code ? 2 : ((data && !m_wr) ? 1 : 0);
                    check(n_ale == x_ale, "R3/R5/R6 ale pulses per cycle", n_ale, x_ale);
                    check(n_psen == x_psen, "R4 psen clocks per cycle", n_psen, x_psen);
                    check(n_rv == x_rv, "R10 captures per cycle", n_rv, x_rv);
                end
            end
        end
        lo_in <= {lo_in[6:0], lo_in[7] ^ lo_in[5] ^ lo_in[4] ^ lo_in[3]};
        if (cyc >= WATCHDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // R11: present one machine cycle's request; slot-1 address given at mid-cycle
    task automatic issue(input logic [2:0] op, input bit wr, input logic [15:0] a0,
                         input logic [15:0] a1, input logic [7:0] wd,
                         input logic [7:0] p2, input bit aoff);
        do @(negedge clk); while (m_ph != 11 || m_rst);
        req_op = op; req_wr = wr; req_addr = a0; req_wdata = wd; p2_reg = p2; ale_off = aoff;
        do @(negedge clk); while (m_ph != 5);
        req_addr = a1;
        // R11: disturbances away from the sampling edges must not matter
        @(negedge clk);
        req_op = 3'd1; req_wr = ~wr; req_wdata = ~wd; p2_reg = ~p2; ale_off = ~aoff;
    endtask

    task automatic hold_reset(input int n);
        @(negedge clk);
        rst_in = 1'b1;
        repeat (n) @(negedge clk);
        rst_in = 1'b0;
    endtask

    initial begin
        // R1: power-up reset longer than two machine cycles
        hold_reset(30);
        check(ale === 0 && psen_n === 1 && rd_n === 1 && wr_n === 1 && lo_oe === 0 && hi_out === 8'hFF,
              "R1 idle outputs after reset", {ale, psen_n, rd_n, wr_n, lo_oe, hi_out},
              {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF});
        issue(3'd0, 0, 16'h1234, 16'h1235, 8'h00, 8'hA5, 0); // R5 idle, ALE on
        issue(3'd0, 0, 16'h1234, 16'h1235, 8'h00, 8'hA5, 1); // R5 idle, ALE off
        issue(3'd1, 0, 16'h2100, 16'h2101, 8'h00, 8'h3C, 1); // R6 fetch ignores off
        issue(3'd2, 0, 16'h47F0, 16'h8801, 8'h00, 8'h3C, 1); // R6 table read
        issue(3'd4, 0, 16'hBEEF, 16'h0000, 8'h00, 8'h77, 1); // R7 16-bit read
        issue(3'd3, 0, 16'h00C3, 16'h0000, 8'h00, 8'h77, 0); // R7 8-bit read shows p2
        issue(3'd4, 1, 16'hCAFE, 16'h0000, 8'h96, 8'h11, 0); // R9 16-bit write
        issue(3'd3, 1, 16'h0042, 16'h0000, 8'h69, 8'hE2, 1); // R9 8-bit write
        issue(3'd6, 0, 16'h5555, 16'hAAAA, 8'h00, 8'h18, 0); // unknown code -> idle
        issue(3'd1, 0, 16'hFFFF, 16'h0000, 8'h00, 8'h18, 0); // boundary addresses
        // R1: short pulse must be ignored, traffic continues
        fork
            hold_reset(10);
            issue(3'd1, 0, 16'h3000, 16'h3001, 8'h00, 8'h00, 0);
        join
        issue(3'd4, 0, 16'h9001, 16'h0000, 8'h00, 8'h00, 0);
        // R1: long reset from the middle of a data cycle
        fork
            issue(3'd4, 1, 16'h7777, 16'h0000, 8'h3E, 8'h00, 0);
            begin repeat (14) @(negedge clk); hold_reset(26); end
        join
        for (int i = 0; i < 40; i++) begin
            logic [15:0] a = 16'(i * 16'h1357 + 16'h0101);
            issue(3'(i % 5), bit'((i / 5) % 2), a, ~a, 8'(i * 7), 8'(i * 13), bit'(i % 3 == 0));
        end
        repeat (14) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule